// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers up to 64 active-low interrupt inputs into one interrupt request line for a processor. Each input passes through a two-flop synchronizer and then a detector whose trigger type depends on the input's class. Internal sources trigger on a low level only. Sources 19 to 25 can trigger on a falling edge or on a low level. Sources 48 to 63 can trigger on a falling edge or on both edges. A detection latches a bit in one of two 32-bit pending words. The position of that bit comes from a fixed, non-arithmetic placement table. Two 32-bit enable words gate the pending bits onto the request line. A vector word reports the lowest-numbered source that is both pending and enabled.

Software reaches the block through a plain register bus. A write takes effect at the clock edge that samples it. A read returns combinationally from the address, and a read has no side effects. There is no back-pressure: every bus access completes in the cycle it is presented. The usual start-up sequence is: disable everything, write all ones to both pending words, and read the vector once. After that sequence the block is quiet.

Top module: `intc_vec64`

## Requirements
- R1: After reset, both enable words, both pending words and the sense word read as zero, `irq` is low and the vector reads zero.
- R2: Register offsets on `bus_addr` are: 0 enable-high, 1 enable-low, 2 pending-high, 3 pending-low, 4 sense, 5 vector. Any other offset reads zero. Source n occupies one slot in the pending and enable words: n=1..15 uses low bit 16-n; n=16..18 uses high bit 18-n; n=19..30 uses high bit 33-n; n=31 uses high bit 0; n=32..47 uses low bit 63-n; n=48..63 uses high bit n-32.
- R3: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. A pending bit that is not cleared stays set.
- R4: An enable bit of 1 passes its slot to `irq`, and an enable bit of 0 blocks it. `irq` is high exactly when some slot is both pending and enabled. Pending bits latch whatever the enable setting.
- R5: The vector word holds, in bits 31:26, the lowest source number whose slot is pending and enabled. All its other bits are zero, and the word is zero when nothing qualifies.
- R6: Internal sources (1..18 and 26..47) set their pending slot in every cycle their synchronized input is low. A clear while the input is still low is overridden. After the input returns high, the bit stays set until it is cleared.
- R7: For sources 19..25, sense bit 33-n set to 1 selects falling-edge detection. A falling-edge bit cleared while the input stays low stays clear. The same sense bit at 0 selects low-level detection, as in R6.
- R8: For sources 48..63, sense bit n-32 set to 1 selects falling-edge detection, so a rising edge sets nothing. The same bit at 0 selects detection of both edges. Only sense bits 31:16 and 14:8 are stored; the others read as zero.
- R9: An input change applied just after clock edge p shows in the pending word after edge p+3 and not before.
- R10: Source 0 never becomes pending: low-word bit 0 stays zero. Sources 18 and 31 share high-word bit 0, and the vector reports 18 for that slot.
- R11: When a detection and a clear of the same pending bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_n | input | 64 | Interrupt inputs, active low; bit n is source n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is a detection event that lands in the same clock cycle as a software clear of the same bit. That cycle depends on the synchronizer depth and on the edge register behind it. The stimulus toggles a both-edge port input just after one edge. It then counts exactly two more edges and presents the clear write, so that both are sampled at the third edge. The same edge counting pins down the three-cycle input latency. It also places clears while level inputs are still held low, and clears falling-edge bits while their inputs stay low.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC = 64;
  localparam int REG_W   = 32;
  localparam int VEC_W   = $clog2(NUM_SRC);
  localparam int ADDR_W  = 3;
  localparam int BIT_W   = $clog2(REG_W);

  localparam logic [ADDR_W-1:0] OFS_EN_HI = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_EN_LO = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PD_HI = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_PD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_VECT  = 3'd5;

  localparam logic [REG_W-1:0] SENSE_KEEP = 32'hFFFF_7F00;

  typedef struct packed {
    logic             hi;
    logic [BIT_W-1:0] pos;
  } slot_t;

  typedef enum logic [1:0] {CLS_LEVEL, CLS_EXTPIN, CLS_PORT} src_cls_t;

  function automatic slot_t slot_of(input int n);
    slot_t s;
    s.hi  = 1'b0;
    s.pos = '0;
    if (n >= 1 && n <= 15)       begin s.hi = 1'b0; s.pos = BIT_W'(16 - n); end
    else if (n >= 16 && n <= 18) begin s.hi = 1'b1; s.pos = BIT_W'(18 - n); end
    else if (n >= 19 && n <= 30) begin s.hi = 1'b1; s.pos = BIT_W'(33 - n); end
    else if (n == 31)            begin s.hi = 1'b1; s.pos = '0; end
    else if (n >= 32 && n <= 47) begin s.hi = 1'b0; s.pos = BIT_W'(63 - n); end
    else if (n >= 48 && n <= 63) begin s.hi = 1'b1; s.pos = BIT_W'(n - 32); end
    return s;
  endfunction

  function automatic src_cls_t class_of(input int n);
    if (n >= 19 && n <= 25) return CLS_EXTPIN;
    if (n >= 48 && n <= 63) return CLS_PORT;
    return CLS_LEVEL;
  endfunction

  function automatic int sense_pos(input int n);
    if (n >= 19 && n <= 25) return 33 - n;
    if (n >= 48 && n <= 63) return n - 32;
    return 0;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/intc_detect.sv
module intc_detect
  import intc_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] lvl_n,
  input  logic [DW-1:0] sense,
  output logic [DW-1:0] hit_hi,
  output logic [DW-1:0] hit_lo
);
  logic [NS-1:0] prev_q;
  logic [NS-1:0] ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_n;
  end

  generate
    for (genvar n = 0; n < NS; n++) begin : g_src
      if (n == 0) begin : g_none
        assign ev[n] = 1'b0;
      end else if (class_of(n) == CLS_EXTPIN) begin : g_ext
        localparam int SB = sense_pos(n);
        logic fall;
        assign fall  = prev_q[n] & ~lvl_n[n];
        assign ev[n] = sense[SB] ? fall : ~lvl_n[n];
        assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (ev[n] && sense[SB]) |=> (!ev[n] || !sense[SB]));
      end else if (class_of(n) == CLS_PORT) begin : g_port
        localparam int SB = sense_pos(n);
        logic fall, any_edge;
        assign fall     = prev_q[n] & ~lvl_n[n];
        assign any_edge = prev_q[n] ^ lvl_n[n];
        assign ev[n]    = sense[SB] ? fall : any_edge;
      end else begin : g_lvl
        assign ev[n] = ~lvl_n[n];
      end
    end
  endgenerate

  always_comb begin
    slot_t sl;
    hit_hi = '0;
    hit_lo = '0;
    for (int n = 1; n < NS; n++) begin
      sl = slot_of(n);
      if (ev[n]) begin
        if (sl.hi) hit_hi[sl.pos] = 1'b1;
        else       hit_lo[sl.pos] = 1'b1;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{sense & ~SENSE_KEEP, lvl_n[0], prev_q[0]};
endmodule

// File: rtl/intc_prio.sv
module intc_prio
  import intc_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int DW = REG_W,
  localparam int VW = $clog2(NS)
) (
  input  logic [DW-1:0] act_hi,
  input  logic [DW-1:0] act_lo,
  output logic [VW-1:0] win,
  output logic          any
);
  always_comb begin
    slot_t sl;
    win = '0;
    for (int n = NS - 1; n >= 1; n--) begin
      sl = slot_of(n);
      if (sl.hi ? act_hi[sl.pos] : act_lo[sl.pos]) win = VW'(n);
    end
  end

  assign any = |{act_hi, act_lo};
endmodule

// File: rtl/intc_vec64.sv
module intc_vec64
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [NUM_SRC-1:0] lvl_n;
  logic [REG_W-1:0]   en_hi, en_lo, pd_hi, pd_lo, sense_q;
  logic [REG_W-1:0]   hit_hi, hit_lo, clr_hi, clr_lo;
  logic [VEC_W-1:0]   win;
  logic               any;

  intc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(src_n), .dout(lvl_n));

  intc_detect #(.NS(NUM_SRC), .DW(REG_W)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl_n(lvl_n), .sense(sense_q),
    .hit_hi(hit_hi), .hit_lo(hit_lo));

  assign clr_hi = (bus_wr && bus_addr == OFS_PD_HI) ? bus_wdata : '0;
  assign clr_lo = (bus_wr && bus_addr == OFS_PD_LO) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_hi   <= '0;
      en_lo   <= '0;
      pd_hi   <= '0;
      pd_lo   <= '0;
      sense_q <= '0;
    end else begin
      pd_hi <= (pd_hi & ~clr_hi) | hit_hi;
      pd_lo <= (pd_lo & ~clr_lo) | hit_lo;
      if (bus_wr && bus_addr == OFS_EN_HI) en_hi   <= bus_wdata;
      if (bus_wr && bus_addr == OFS_EN_LO) en_lo   <= bus_wdata;
      if (bus_wr && bus_addr == OFS_SENSE) sense_q <= bus_wdata & SENSE_KEEP;
    end
  end

  intc_prio #(.NS(NUM_SRC), .DW(REG_W)) u_prio (
    .act_hi(pd_hi & en_hi), .act_lo(pd_lo & en_lo), .win(win), .any(any));

  assign irq = any;

  always_comb begin
    case (bus_addr)
      OFS_EN_HI: bus_rdata = en_hi;
      OFS_EN_LO: bus_rdata = en_lo;
      OFS_PD_HI: bus_rdata = pd_hi;
      OFS_PD_LO: bus_rdata = pd_lo;
      OFS_SENSE: bus_rdata = sense_q;
      OFS_VECT:  bus_rdata = {win, {(REG_W-VEC_W){1'b0}}};
      default:   bus_rdata = '0;
    endcase
  end

  slot_t win_sl;
  logic  win_live;
  always_comb begin
    win_sl   = slot_of(int'(win));
    win_live = win_sl.hi ? (pd_hi[win_sl.pos] & en_hi[win_sl.pos])
                         : (pd_lo[win_sl.pos] & en_lo[win_sl.pos]);
  end

  assert_vec_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (win != '0 && win_live));

  assert_irq_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_hi | en_lo) == '0) |-> !irq);

  assert_pend_hold_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_PD_HI) |=> ((pd_hi & $past(pd_hi)) == $past(pd_hi)));

  assert_pend_hold_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_PD_LO) |=> ((pd_lo & $past(pd_lo)) == $past(pd_lo)));

  assert_src0_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_lo[0]);
endmodule

// File: tb/sim_intc_vec64.sv
module sim_intc_vec64;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_vec64 u0 (.clk(clk), .rst_n(rst_n), .src_n(src_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // ---------- behavioural reference ----------
  function automatic bit in_hi(int n);
    return !((n < 16) || (n > 31 && n < 48));
  endfunction
  function automatic int pos_of(int n);
    if (n < 16) return 16 - n;
    if (n < 19) return 18 - n;
    if (n < 31) return 33 - n;
    if (n == 31) return 0;
    if (n < 48) return 63 - n;
    return n - 32;
  endfunction

  logic [63:0] m_s1 = '1, m_s2 = '1, m_prev = '1;
  logic [31:0] m_eh = 0, m_el = 0, m_ph = 0, m_pl = 0, m_se = 0;

  always @(posedge clk) begin
    logic [31:0] sh, sl, ch, cl;
    bit e, cur, pv;
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_prev = '1;
      m_eh = 0; m_el = 0; m_ph = 0; m_pl = 0; m_se = 0;
    end else begin
      sh = 0; sl = 0;
      for (int n = 1; n < 64; n++) begin
        cur = m_s2[n]; pv = m_prev[n];
        if (n >= 19 && n <= 25)      e = m_se[33-n] ? (pv && !cur) : !cur;
        else if (n >= 48)            e = m_se[n-32] ? (pv && !cur) : (pv != cur);
        else                         e = !cur;
        if (e) begin
          if (in_hi(n)) sh[pos_of(n)] = 1'b1;
          else          sl[pos_of(n)] = 1'b1;
        end
      end
      ch = (bus_wr && bus_addr == 3'd2) ? bus_wdata : 32'h0;
      cl = (bus_wr && bus_addr == 3'd3) ? bus_wdata : 32'h0;
      m_ph = (m_ph & ~ch) | sh;
      m_pl = (m_pl & ~cl) | sl;
      if (bus_wr && bus_addr == 3'd0) m_eh = bus_wdata;
      if (bus_wr && bus_addr == 3'd1) m_el = bus_wdata;
      if (bus_wr && bus_addr == 3'd4) m_se = bus_wdata & 32'hFFFF_7F00;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = src_n;
    end
  end

  function automatic int m_vec();
    for (int n = 1; n < 64; n++) begin
      if (in_hi(n) ? (m_ph[pos_of(n)] & m_eh[pos_of(n)]) : (m_pl[pos_of(n)] & m_el[pos_of(n)]))
        return n;
    end
    return 0;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_eh;
      3'd1: return m_el;
      3'd2: return m_ph;
      3'd3: return m_pl;
      3'd4: return m_se;
      3'd5: return {6'(m_vec()), 26'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 R5 model irq", {31'h0, irq}, {31'h0, ((m_ph & m_eh) | (m_pl & m_el)) != 0});
      chk("R2 R3 model rdata", bus_rdata, m_read(bus_addr));
    end
  end

  // ---------- stimulus helpers ----------
  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic drive(int n, logic val);
    @(posedge clk); #1;
    src_n[n] = val;
  endtask

  task automatic idle(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 enable-high reset", v, 32'h0);
    rd(3'd1, v); chk("R1 enable-low reset", v, 32'h0);
    rd(3'd4, v); chk("R1 sense reset", v, 32'h0);
    rd(3'd5, v); chk("R1 vector reset", v, 32'h0);
    chk("R1 irq reset", {31'h0, irq}, 32'h0);

    // start-up sequence, R3
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R3 init vector", v, 32'h0);

    // R9 latency: source 3 -> low bit 13
    @(posedge clk); #1 bus_addr = 3'd3; src_n[3] = 1'b0;
    repeat (3) begin
      @(negedge clk); chk("R9 not yet pending", bus_rdata & 32'h2000, 32'h0);
    end
    @(negedge clk); chk("R9 pending after third edge", bus_rdata & 32'h2000, 32'h2000);
    chk("R4 masked source gives no irq", {31'h0, irq}, 32'h0);
    drive(3, 1'b1); idle(4);
    wr(3'd3, 32'h2000);
    rd(3'd3, v); chk("R3 clear source 3", v, 32'h0);

    // R4 R5 R6 with source 5 -> low bit 11
    drive(5, 1'b0); idle(4);
    rd(3'd3, v); chk("R6 level latch", v, 32'h800);
    chk("R4 irq blocked by enable", {31'h0, irq}, 32'h0);
    wr(3'd1, 32'h800);
    @(negedge clk); chk("R4 irq when enabled", {31'h0, irq}, 32'h1);
    rd(3'd5, v); chk("R5 vector source 5", v, 32'h1400_0000);
    wr(3'd3, 32'h800);
    rd(3'd3, v); chk("R6 relatch while low", v, 32'h800);
    drive(5, 1'b1); idle(4);
    rd(3'd3, v); chk("R6 held after release", v, 32'h800);
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R3 zero write keeps bit", v, 32'h800);
    wr(3'd3, 32'h800);
    rd(3'd3, v); chk("R3 one write clears", v, 32'h0);
    @(negedge clk); chk("R4 irq drops", {31'h0, irq}, 32'h0);

    // R5 priority: source 5 and 40 (low bit 23)
    wr(3'd1, 32'h0080_0800);
    drive(40, 1'b0); drive(5, 1'b0); idle(4);
    rd(3'd5, v); chk("R5 lowest number wins", v, 32'h1400_0000);
    drive(5, 1'b1); idle(4); wr(3'd3, 32'h800);
    rd(3'd5, v); chk("R5 next source wins", v, 32'hA000_0000);
    drive(40, 1'b1); idle(4); wr(3'd3, 32'h0080_0000);
    rd(3'd5, v); chk("R5 vector empty", v, 32'h0);

    // R7 source 20 -> high bit 13, sense bit 13
    wr(3'd0, 32'h2000); wr(3'd4, 32'h2000);
    drive(20, 1'b0); idle(2); drive(20, 1'b1); idle(4);
    rd(3'd2, v); chk("R7 falling edge latched", v, 32'h2000);
    rd(3'd5, v); chk("R7 vector source 20", v, 32'h5000_0000);
    wr(3'd2, 32'h2000);
    rd(3'd2, v); chk("R7 edge clear", v, 32'h0);
    drive(20, 1'b0); idle(4); wr(3'd2, 32'h2000);
    rd(3'd2, v); chk("R7 edge stays clear while low", v, 32'h0);
    drive(20, 1'b1); idle(4);
    wr(3'd4, 32'h0);
    drive(20, 1'b0); idle(4); wr(3'd2, 32'h2000);
    rd(3'd2, v); chk("R7 level mode relatch", v, 32'h2000);
    drive(20, 1'b1); idle(4); wr(3'd2, 32'h2000);
    rd(3'd2, v); chk("R7 level cleared", v, 32'h0);

    // R8 source 50 -> high bit 18, sense bit 18
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R8 sense stored bits", v, 32'hFFFF_7F00);
    wr(3'd4, 32'h0);
    drive(50, 1'b0); idle(4);
    rd(3'd2, v); chk("R8 both-edge fall", v, 32'h0004_0000);
    wr(3'd2, 32'h0004_0000);
    drive(50, 1'b1); idle(4);
    rd(3'd2, v); chk("R8 both-edge rise", v, 32'h0004_0000);
    wr(3'd2, 32'h0004_0000);
    wr(3'd4, 32'h0004_0000);
    drive(50, 1'b0); idle(4);
    rd(3'd2, v); chk("R8 falling mode fall", v, 32'h0004_0000);
    wr(3'd2, 32'h0004_0000);
    drive(50, 1'b1); idle(4);
    rd(3'd2, v); chk("R8 falling mode ignores rise", v, 32'h0);

    // R10 source 0, shared slot 18/31
    drive(0, 1'b0); idle(4);
    rd(3'd3, v); chk("R10 source 0 never pending", v, 32'h0);
    drive(0, 1'b1);
    wr(3'd0, 32'h1);
    drive(31, 1'b0); idle(4);
    rd(3'd2, v); chk("R10 source 31 on high bit 0", v, 32'h1);
    rd(3'd5, v); chk("R10 shared slot reports 18", v, 32'h4800_0000);
    drive(31, 1'b1); idle(4); wr(3'd2, 32'h1);
    drive(18, 1'b0); idle(4);
    rd(3'd2, v); chk("R10 source 18 on high bit 0", v, 32'h1);
    drive(18, 1'b1); idle(4); wr(3'd2, 32'h1);
    rd(3'd2, v); chk("R10 shared slot cleared", v, 32'h0);

    // R11 detection and clear in the same cycle (source 50 both edges)
    wr(3'd4, 32'h0);
    @(posedge clk); #1 src_n[50] = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1 bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0004_0000;
    @(posedge clk); #1 bus_wr = 1'b0;
    rd(3'd2, v); chk("R11 set beats clear", v, 32'h0004_0000);
    drive(50, 1'b1); idle(4); wr(3'd2, 32'h0004_0000);
    rd(3'd2, v); chk("R11 final clear", v, 32'h0);

    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule